// File: doc/BRIEF.md
# Set-Dueling Policy Selector

This block chooses which of two cache replacement policies the non-sampled (follower) sets of a 16-way cache should use. A fixed group of 32 sampled sets each keeps two shadow directories of 16-bit partial tags, one per competing policy. Each access to a sampled set is looked up in both shadow directories. Each directory reports hit or miss on its own. On a miss it fills the way that its policy names on a victim-way input. The replacement policies themselves live outside the block and reach it only through those two victim-way inputs.

A saturating counter is trained only when the two shadow directories disagree on the same access. It moves toward the policy that hit, and its top bit is the policy-select output that the follower sets obey. A set is sampled when its low five set-index bits equal the next five bits above them. The low five bits then name one of the 32 sampled slots.

Top module: `dueling_selector`

## Requirements
- R1: One cycle after `acc_valid` is high with a sampled set index, `res_valid` is 1. A set index is sampled when bits [SAMPLE_BITS-1:0] equal bits [2*SAMPLE_BITS-1:SAMPLE_BITS]. In every other cycle `res_valid` is 0.
- R2: With `res_valid`, `res_hit0` (or `res_hit1`) is 1 exactly when the shadow directory of policy 0 (or 1) held a valid entry with the access's partial tag in that sampled slot before the access.
- R3: When a shadow directory misses, it writes the partial tag into the way given by its own victim input (`victim0` for policy 0, `victim1` for policy 1) and marks that way valid. The entry overwritten there is lost.
- R4: When a shadow directory hits, its victim input is ignored and its contents are left unchanged.
- R5: After reset every shadow entry is invalid, including tag value 0. `res_valid` is 0, and the counter sits at its midpoint 2^(CNT_W-1), so `use_policy1` is 1.
- R6: The counter increments when policy 0 misses and policy 1 hits, and decrements when policy 0 hits and policy 1 misses. It is unchanged when both policies agree. `use_policy1` is the counter MSB and changes in the same cycle as `res_valid` for the access that moved it.
- R7: The counter saturates: it stays at 2^CNT_W-1 on a further increment and at 0 on a further decrement.
- R8: An access with `acc_valid` low, or an access to a non-sampled set, changes neither shadow directory nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_BITS | Set index of the access |
| acc_ptag | input | PTAG_W | Partial tag of the access |
| victim0 | input | $clog2(WAYS) | Way policy 0 would replace on a miss |
| victim1 | input | $clog2(WAYS) | Way policy 1 would replace on a miss |
| res_valid | output | 1 | Last cycle's access hit a sampled set |
| res_hit0 | output | 1 | Policy 0 shadow directory hit |
| res_hit1 | output | 1 | Policy 1 shadow directory hit |
| use_policy1 | output | 1 | Followers use policy 1 (1) or policy 0 (0) |

## Verification
The assertions assume a few things about the inputs. The victim indices always name a real way. Every input is known whenever `acc_valid` is high. Reset is held for at least one clock before use. Under those conditions a shadow slot can never hold two matching ways, because fills happen only on misses. The stimulus drives every input at the falling edge from a defined value, holds reset for several cycles, and uses a reduced configuration of 64 sets, 8 sampled slots and a 4-bit counter. That small configuration lets the bench reach both counter rails and sweep every set index while it models each shadow entry arithmetically.

// File: rtl/dueling_pkg.sv
// dueling_pkg: shared defaults and helpers for the set-dueling selector.
// Assumes the way count is a power of two.
package dueling_pkg;
    localparam int DEF_SET_BITS    = 10;
    localparam int DEF_SAMPLE_BITS = 5;
    localparam int DEF_WAYS        = 16;
    localparam int DEF_PTAG_W      = 16;
    localparam int DEF_CNT_W       = 10;

    // Which competing policy a shadow directory models.
    typedef enum logic { POLICY0 = 1'b0, POLICY1 = 1'b1 } policy_e;
endpackage

// File: rtl/sample_filter.sv
// sample_filter: decides whether a set index belongs to the sampled group
// and, if so, which shadow slot it uses. Assumes SET_BITS >= 2*SAMPLE_BITS.
module sample_filter #(
    parameter int SET_BITS    = 10,
    parameter int SAMPLE_BITS = 5
) (
    input  logic [SET_BITS-1:0]    set_idx,
    output logic                   is_sampled,
    output logic [SAMPLE_BITS-1:0] slot
);
    // Compare the low index field against the field directly above it.
    always_comb begin
        slot       = set_idx[SAMPLE_BITS-1:0];
        is_sampled = (set_idx[SAMPLE_BITS-1:0] == set_idx[2*SAMPLE_BITS-1:SAMPLE_BITS]);
    end
endmodule

// File: rtl/shadow_dir.sv
// shadow_dir: partial-tag shadow directory for one competing policy across
// all sampled slots. Lookup is combinational; on a miss the tag is written
// into the way chosen by the policy's victim input at the next clock edge.
// Assumes victim always names an existing way.
module shadow_dir #(
    parameter int SLOT_BITS = 5,
    parameter int WAYS      = 16,
    parameter int PTAG_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lookup_en,
    input  logic [SLOT_BITS-1:0]    slot,
    input  logic [PTAG_W-1:0]       tag,
    input  logic [$clog2(WAYS)-1:0] victim,
    output logic                    hit
);
    localparam int SLOTS = 1 << SLOT_BITS;
    localparam int WAY_W = $clog2(WAYS);

    logic [SLOTS-1:0][WAYS-1:0] valid_q;
    logic [PTAG_W-1:0]          tag_mem [SLOTS][WAYS];
    logic [WAYS-1:0]            way_match;
    logic                       fill_en;

    // Per-way tag compare within the addressed slot.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            way_match[w] = valid_q[slot][w] && (tag_mem[slot][w] == tag);
        end
        hit     = |way_match;
        fill_en = lookup_en && !hit;
    end

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[slot][victim] <= 1'b1;
        end
    end

    // Tag storage: written on a fill, never reset (guarded by valid bits).
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[slot][victim] <= tag;
        end
    end

    // R2: fills happen only on misses, so at most one way can match.
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |-> $onehot0(way_match));

    // R3: a miss leaves the victim way valid and holding the new tag.
    assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(slot)][$past(victim)] &&
                     tag_mem[$past(slot)][$past(victim)] == $past(tag)));

    // R4 / R8: without a fill the valid bits do not move.
    assert_keep_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(valid_q));

    localparam int UNUSED_WAY_W = WAY_W;
endmodule

// File: rtl/duel_counter.sv
// duel_counter: saturating policy-selection counter. Starts at its midpoint,
// steps up when only policy 1 hit, down when only policy 0 hit.
// Assumes step_up and step_dn are never high together.
module duel_counter #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_up,
    input  logic step_dn,
    output logic sel_msb
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_q;

    // Saturating up/down count with midpoint reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MID;
        end else if (step_up && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (step_dn && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Select output is the counter's top bit.
    always_comb sel_msb = cnt_q[CNT_W-1];

    // R7: no wrap at either rail.
    assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && cnt_q == '0) |=> cnt_q == '0);

    // R6: agreement holds the count.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !step_dn) |=> $stable(cnt_q));
endmodule

// File: rtl/dueling_selector.sv
// dueling_selector: set-dueling policy selector. Filters sampled sets, looks
// each sampled access up in two shadow directories (one per policy), and
// trains a saturating counter on disagreement. Results are registered and
// appear one cycle after the access. Assumes victim inputs are in range.
module dueling_selector
    import dueling_pkg::*;
#(
    parameter int SET_BITS    = DEF_SET_BITS,
    parameter int SAMPLE_BITS = DEF_SAMPLE_BITS,
    parameter int WAYS        = DEF_WAYS,
    parameter int PTAG_W      = DEF_PTAG_W,
    parameter int CNT_W       = DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [SET_BITS-1:0]     acc_set,
    input  logic [PTAG_W-1:0]       acc_ptag,
    input  logic [$clog2(WAYS)-1:0] victim0,
    input  logic [$clog2(WAYS)-1:0] victim1,
    output logic                    res_valid,
    output logic                    res_hit0,
    output logic                    res_hit1,
    output logic                    use_policy1
);
    localparam int WAY_W = $clog2(WAYS);

    logic                   is_sampled;
    logic [SAMPLE_BITS-1:0] slot;
    logic                   lookup_en;
    logic [WAY_W-1:0]       victim [2];
    logic                   hit    [2];

    sample_filter #(.SET_BITS(SET_BITS), .SAMPLE_BITS(SAMPLE_BITS)) u_filter (
        .set_idx    (acc_set),
        .is_sampled (is_sampled),
        .slot       (slot)
    );

    // Qualify the access and route each policy's victim choice.
    always_comb begin
        lookup_en = acc_valid && is_sampled;
        victim[POLICY0] = victim0;
        victim[POLICY1] = victim1;
    end

    // One shadow directory per competing policy.
    for (genvar p = 0; p < 2; p++) begin : g_shadow
        shadow_dir #(.SLOT_BITS(SAMPLE_BITS), .WAYS(WAYS), .PTAG_W(PTAG_W)) u_dir (
            .clk       (clk),
            .rst_n     (rst_n),
            .lookup_en (lookup_en),
            .slot      (slot),
            .tag       (acc_ptag),
            .victim    (victim[p]),
            .hit       (hit[p])
        );
    end

    duel_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (lookup_en && !hit[POLICY0] && hit[POLICY1]),
        .step_dn (lookup_en && hit[POLICY0] && !hit[POLICY1]),
        .sel_msb (use_policy1)
    );

    // Register the lookup outcome for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit0  <= 1'b0;
            res_hit1  <= 1'b0;
        end else begin
            res_valid <= lookup_en;
            res_hit0  <= lookup_en && hit[POLICY0];
            res_hit1  <= lookup_en && hit[POLICY1];
        end
    end

    // R8: idle or non-sampled access yields no result next cycle.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && is_sampled) |=> !res_valid);

    // R6: a reported agreement leaves the select output where it was.
    assert_agree_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit0 == res_hit1) |-> $stable(use_policy1));

    // R1: hit flags only accompany a valid result.
    assert_flags_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit0 && !res_hit1));
endmodule

// File: tb/dueling_selector_bench.sv
module dueling_selector_bench;
    localparam int SB = 6, SMP = 3, WAYS = 16, PW = 16, CW = 4;
    localparam int SLOTS = 1 << SMP;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [SB-1:0] acc_set = '0;
    logic [PW-1:0] acc_ptag = '0;
    logic [3:0] victim0 = '0, victim1 = '0;
    logic res_valid, res_hit0, res_hit1, use_policy1;

    int checks = 0, errors = 0;
    logic [PW-1:0] m_tag [2][SLOTS][WAYS];
    bit            m_val [2][SLOTS][WAYS];
    int            m_cnt;

    always #2.5 clk = ~clk;

    dueling_selector #(.SET_BITS(SB), .SAMPLE_BITS(SMP), .WAYS(WAYS),
                       .PTAG_W(PW), .CNT_W(CW)) u_dueling_selector (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_ptag(acc_ptag), .victim0(victim0), .victim1(victim1),
        .res_valid(res_valid), .res_hit0(res_hit0), .res_hit1(res_hit1),
        .use_policy1(use_policy1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input int p, input int s, input logic [PW-1:0] t);
        for (int w = 0; w < WAYS; w++)
            if (m_val[p][s][w] && m_tag[p][s][w] == t) return 1'b1;
        return 1'b0;
    endfunction

    // One access: drive at falling edge, check one cycle later.
    task automatic access(input bit vld, input int set, input int tag, input int v0, input int v1);
        bit smp, h0, h1;
        int s;
        @(negedge clk);
        acc_valid = vld; acc_set = set[SB-1:0]; acc_ptag = tag[PW-1:0];
        victim0 = v0[3:0]; victim1 = v1[3:0];
        s   = set % SLOTS;
        smp = vld && ((set % SLOTS) == ((set / SLOTS) % SLOTS));
        h0 = 0; h1 = 0;
        if (smp) begin
            h0 = model_hit(0, s, tag[PW-1:0]);
            h1 = model_hit(1, s, tag[PW-1:0]);
            if (!h0) begin m_val[0][s][v0] = 1; m_tag[0][s][v0] = tag[PW-1:0]; end
            if (!h1) begin m_val[1][s][v1] = 1; m_tag[1][s][v1] = tag[PW-1:0]; end
            if (!h0 && h1 && m_cnt < CMAX) m_cnt++;
            else if (h0 && !h1 && m_cnt > 0) m_cnt--;
        end
        @(negedge clk);
        acc_valid = 1'b0;
        check(res_valid == smp, smp ? "R1 res_valid sampled" : "R8 res_valid idle",
              int'(res_valid), int'(smp));
        if (smp) begin
            check(res_hit0 == h0, "R2/R3/R4 res_hit0", int'(res_hit0), int'(h0));
            check(res_hit1 == h1, "R2/R3/R4 res_hit1", int'(res_hit1), int'(h1));
        end
        check(use_policy1 == m_cnt[CW-1], "R6/R7 use_policy1", int'(use_policy1), m_cnt[CW-1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < SLOTS; s++)
                for (int w = 0; w < WAYS; w++) begin m_val[p][s][w] = 0; m_tag[p][s][w] = '0; end
        m_cnt = 1 << (CW - 1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        check(res_valid == 1'b0, "R5 res_valid after reset", int'(res_valid), 0);
        check(use_policy1 == 1'b1, "R5 use_policy1 midpoint", int'(use_policy1), 1);
        // R5: tag 0 must miss in a fresh directory
        access(1, 0, 0, 0, 0);
        // R8: idle strobe into sampled set must not fill; later lookup misses
        access(0, 9, 77, 3, 3);
        access(1, 9, 77, 4, 5);
        // R8: non-sampled set access does not count and is ignored
        access(1, 10, 55, 0, 0);
        // R1: sweep every set index
        for (int st = 0; st < (1 << SB); st++) access(1, st, 1000 + st, st % WAYS, (st * 3) % WAYS);
        // R4: hit with a victim pointing at another way must not disturb it
        access(1, 18, 300, 6, 6);
        access(1, 18, 301, 7, 7);
        access(1, 18, 300, 7, 7);
        access(1, 18, 301, 0, 0);
        // R3: overwriting a victim loses the old tag
        access(1, 18, 302, 6, 8);
        access(1, 18, 300, 9, 9);
        // R6/R7: policy 0 thrashes, counter climbs to the top rail
        for (int i = 0; i < 20; i++) begin
            access(1, 27, 100, 0, 1);
            access(1, 27, 101, 0, 2);
        end
        // R6/R7: policy 1 thrashes, counter falls to the bottom rail
        for (int i = 0; i < 40; i++) begin
            access(1, 36, 200, 1, 0);
            access(1, 36, 201, 2, 0);
        end
        // Mixed random traffic with a small tag space
        for (int i = 0; i < 3000; i++) begin
            int sl, st;
            sl = $urandom_range(0, SLOTS - 1);
            st = ($urandom_range(0, 3) == 0) ? $urandom_range(0, (1 << SB) - 1) : sl * SLOTS + sl;
            access($urandom_range(0, 7) != 0, st, $urandom_range(0, 23),
                   $urandom_range(0, WAYS - 1), $urandom_range(0, WAYS - 1));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule